// File: doc/BRIEF.md
# Write-only I2C command-word receiver

This block is a receive-only I2C target that sits on the system clock and oversamples the bus lines. It watches SCL and SDA for START and STOP conditions, shifts in the first byte of each transfer, and compares the 7-bit address in it against a configured address and a hardwired broadcast address. When either address matches and the direction bit requests a write, it acknowledges. It then takes in three data bytes and acknowledges each one. When the third byte is complete, it presents the 24-bit word for one clock cycle.

Read requests, addresses that do not match, and data bytes after the third are never acknowledged. A START or STOP that arrives inside a byte drops the partial transfer without issuing a word. SDA is driven only through an output enable: when the enable is high, the pad pulls the line low. The address comes in as a plain 7-bit input.

Top module: `cmdword_i2c_rx`

## Requirements
- R1: While rst_ni is low, and after its release with the bus idle, sda_oe_o, word_valid_o and busy_o are all 0.
- R2: After a START, bits are taken on rising SCL edges, MSB first: a 7-bit address, then a direction bit (0 = write). If the address equals own_addr_i and the direction bit is 0, sda_oe_o is high through the whole high phase of the 9th clock.
- R3: The fixed broadcast address 7'b1110011 (0x73) is acknowledged with a write direction in the same way as own_addr_i.
- R4: An address that matches neither own_addr_i nor the broadcast address is not acknowledged. No later byte of that transfer is acknowledged, no word is issued and busy_o stays 0.
- R5: A matching address with direction bit 1 is not acknowledged. The rest of that transfer is ignored: no acknowledge, no word.
- R6: Each of the first three data bytes after an accepted address is acknowledged. After the third, word_valid_o is high for exactly one cycle, and word_o = {byte1, byte2, byte3}. Byte 1 occupies bits 23:16; its upper nibble, word_o[23:20], is the command.
- R7: A fourth or later data byte in the same transfer is not acknowledged (SDA stays high on its 9th clock) and causes no further word.
- R8: A START or STOP in the middle of a byte ends the transfer without issuing a word. After a START, the next byte is treated as a new address byte.
- R9: busy_o rises together with the acknowledge of an accepted address. It stays high through the first two data bytes and falls in the same cycle that word_valid_o pulses. A START or STOP clears it.
- R10: sda_oe_o changes only while the synchronised SCL is low. It is released after the falling edge of the 9th clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| own_addr_i | input | 7 | Configured 7-bit target address |
| sda_oe_o | output | 1 | High pulls SDA low (acknowledge) |
| word_o | output | 24 | Last completed command word |
| word_valid_o | output | 1 | One-cycle strobe when word_o is updated |
| busy_o | output | 1 | Accepted write in progress, word not yet complete |

## Verification
Transfers are aimed at the own address, at the broadcast address, and at unrelated addresses, each with both direction bits. This separates the two match paths from the direction check. Payloads of zero to five data bytes show where acknowledging stops and confirm that exactly one word comes out per accepted transfer. Directed cases stop a transfer part way through a byte and restart one mid-byte, to show that a partial word is dropped and that the next address byte is framed correctly. Random payload values make sure that byte order and bit order in word_o are not confused.

// File: rtl/cwi_pkg.sv
package cwi_pkg;
  localparam logic [6:0] BCAST_ADDR_DEF = 7'b1110011;
  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA, ST_SKIP} rx_state_e;
endpackage

// File: rtl/cwi_line_sync.sv
module cwi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic q_prev_o
);
  // one extra stage keeps the previous synchronised value for edge detection
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-1:0], d_i};
  end

  assign q_o      = pipe_q[STAGES-1];
  assign q_prev_o = pipe_q[STAGES];
endmodule

// File: rtl/cwi_bus_events.sv
module cwi_bus_events (
  input  logic scl_i,
  input  logic scl_prev_i,
  input  logic sda_i,
  input  logic sda_prev_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_held;

  assign scl_held   = scl_i & scl_prev_i;
  assign scl_rise_o = scl_i & ~scl_prev_i;
  assign scl_fall_o = ~scl_i & scl_prev_i;
  assign start_o    = scl_held & sda_prev_i & ~sda_i;
  assign stop_o     = scl_held & ~sda_prev_i & sda_i;
endmodule

// File: rtl/cwi_rx_core.sv
module cwi_rx_core
  import cwi_pkg::*;
#(
  parameter int         WORD_BYTES = 3,
  parameter logic [6:0] BCAST_ADDR = BCAST_ADDR_DEF,
  localparam int        WORD_W     = 8 * WORD_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [6:0]        own_addr_i,
  output logic              sda_oe_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o,
  output logic              busy_o
);
  localparam int              BCNT_W    = $clog2(WORD_BYTES + 1);
  localparam logic [BCNT_W-1:0] NBYTES  = BCNT_W'(WORD_BYTES);
  localparam logic [BCNT_W-1:0] LAST_BY = BCNT_W'(WORD_BYTES - 1);

  rx_state_e         st_q;
  logic [3:0]        bit_cnt_q;
  logic [7:0]        shreg_q;
  logic [BCNT_W-1:0] byte_cnt_q;
  logic [WORD_W-1:0] asm_q;
  logic [WORD_W-1:0] word_q;
  logic              oe_q, wv_q, busy_q;
  logic              addr_hit, rd_req, in_xfer;

  assign addr_hit = (shreg_q[7:1] == own_addr_i) || (shreg_q[7:1] == BCAST_ADDR);
  assign rd_req   = shreg_q[0];
  assign in_xfer  = (st_q == ST_ADDR) || (st_q == ST_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      bit_cnt_q  <= '0;
      shreg_q    <= '0;
      byte_cnt_q <= '0;
      asm_q      <= '0;
      word_q     <= '0;
      oe_q       <= 1'b0;
      wv_q       <= 1'b0;
      busy_q     <= 1'b0;
    end else begin
      wv_q <= 1'b0;
      if (start_i) begin
        st_q       <= ST_ADDR;
        bit_cnt_q  <= '0;
        byte_cnt_q <= '0;
        oe_q       <= 1'b0;
        busy_q     <= 1'b0;
      end else if (stop_i) begin
        st_q      <= ST_IDLE;
        bit_cnt_q <= '0;
        oe_q      <= 1'b0;
        busy_q    <= 1'b0;
      end else if (in_xfer) begin
        if (scl_rise_i && bit_cnt_q < 4'd9) begin
          if (bit_cnt_q < 4'd8) shreg_q <= {shreg_q[6:0], sda_i};
          bit_cnt_q <= bit_cnt_q + 4'd1;
        end else if (scl_fall_i) begin
          if (bit_cnt_q == 4'd8) begin
            // byte complete: decide acknowledge for the 9th clock
            if (st_q == ST_ADDR) begin
              if (addr_hit && !rd_req) begin
                oe_q       <= 1'b1;
                busy_q     <= 1'b1;
                byte_cnt_q <= '0;
                st_q       <= ST_DATA;
              end else begin
                st_q <= ST_SKIP;
              end
            end else if (byte_cnt_q < NBYTES) begin
              oe_q       <= 1'b1;
              asm_q      <= {asm_q[WORD_W-9:0], shreg_q};
              byte_cnt_q <= byte_cnt_q + 1'b1;
              if (byte_cnt_q == LAST_BY) begin
                word_q <= {asm_q[WORD_W-9:0], shreg_q};
                wv_q   <= 1'b1;
                busy_q <= 1'b0;
              end
            end
          end else if (bit_cnt_q == 4'd9) begin
            oe_q      <= 1'b0;
            bit_cnt_q <= '0;
          end
        end
      end
    end
  end

  assign sda_oe_o     = oe_q;
  assign word_o       = word_q;
  assign word_valid_o = wv_q;
  assign busy_o       = busy_q;
endmodule

// File: rtl/cmdword_i2c_rx.sv
module cmdword_i2c_rx
  import cwi_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         WORD_BYTES  = 3,
  parameter logic [6:0] BCAST_ADDR  = BCAST_ADDR_DEF,
  localparam int        WORD_W      = 8 * WORD_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [6:0]        own_addr_i,
  output logic              sda_oe_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o,
  output logic              busy_o
);
  localparam int NLINES = 2;  // index 0 = SCL, 1 = SDA

  logic [NLINES-1:0] line_raw, line_s, line_p;
  logic scl_s, scl_p, sda_s, sda_p;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_sync
    cwi_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .d_i      (line_raw[g]),
      .q_o      (line_s[g]),
      .q_prev_o (line_p[g])
    );
  end

  assign scl_s = line_s[0];
  assign scl_p = line_p[0];
  assign sda_s = line_s[1];
  assign sda_p = line_p[1];

  cwi_bus_events i_events (
    .scl_i      (scl_s),
    .scl_prev_i (scl_p),
    .sda_i      (sda_s),
    .sda_prev_i (sda_p),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_ev),
    .stop_o     (stop_ev)
  );

  cwi_rx_core #(
    .WORD_BYTES (WORD_BYTES),
    .BCAST_ADDR (BCAST_ADDR)
  ) i_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sda_i        (sda_s),
    .scl_rise_i   (scl_rise),
    .scl_fall_i   (scl_fall),
    .start_i      (start_ev),
    .stop_i       (stop_ev),
    .own_addr_i   (own_addr_i),
    .sda_oe_o     (sda_oe_o),
    .word_o       (word_o),
    .word_valid_o (word_valid_o),
    .busy_o       (busy_o)
  );
endmodule

// File: rtl/cmdword_i2c_rx_chk.sv
module cmdword_i2c_rx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_s,
  input logic sda_oe_o,
  input logic word_valid_o,
  input logic busy_o
);
  // R10
  oe_rise_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s);

  // R10
  oe_fall_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_o) |-> !scl_s);

  // R6
  word_strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |=> !word_valid_o);

  // R9
  busy_ends_with_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> $fell(busy_o));

  // R9
  busy_starts_with_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> sda_oe_o);
endmodule

bind cmdword_i2c_rx cmdword_i2c_rx_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .scl_s        (scl_s),
  .sda_oe_o     (sda_oe_o),
  .word_valid_o (word_valid_o),
  .busy_o       (busy_o)
);

// File: tb/test_cmdword_i2c_rx.sv
module test_cmdword_i2c_rx;
  localparam int Q = 8;
  localparam logic [6:0] BCAST = 7'b1110011;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic [6:0]  own_addr = 7'h12;
  logic        sda_oe;
  logic [23:0] word;
  logic        word_valid;
  logic        busy;
  wire         sda_line = sda_m & ~sda_oe;

  int n_checks = 0;
  int n_fails  = 0;
  int wv_cnt   = 0;
  int wv_double = 0;
  logic [23:0] last_word = '0;
  logic wv_prev = 1'b0;

  always #2 clk = ~clk;

  cmdword_i2c_rx i_cmdword_i2c_rx (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .scl_i        (scl_m),
    .sda_i        (sda_line),
    .own_addr_i   (own_addr),
    .sda_oe_o     (sda_oe),
    .word_o       (word),
    .word_valid_o (word_valid),
    .busy_o       (busy)
  );

  always @(negedge clk) begin
    if (word_valid) begin
      wv_cnt++;
      last_word = word;
      if (wv_prev) wv_double++;
    end
    wv_prev = word_valid;
  end

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit addr_ok(input logic [6:0] a, input bit rw, input logic [6:0] own);
    return ((a == own) || (a == BCAST)) && !rw;
  endfunction

  task automatic bus_start;
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq(Q);
      scl_m = 1'b1; wq(2 * Q);
      scl_m = 1'b0; wq(Q);
    end
  endtask

  // returns SDA sampled early and late in the 9th clock high phase
  task automatic send_byte(input logic [7:0] b, output logic [1:0] ack_s);
    send_bits(b, 8);
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(1);
    ack_s[1] = sda_line;
    wq(2 * Q - 2);
    ack_s[0] = sda_line;
    wq(1);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic run_txn(input logic [6:0] a, input bit rw, input logic [6:0] own,
                         input int nbytes, input logic [7:0] d0, input logic [7:0] d1,
                         input logic [7:0] d2, input logic [7:0] d3, input logic [7:0] d4);
    logic [1:0] s;
    logic [7:0] db [5];
    bit ok;
    int wv0;
    string rq;
    db[0] = d0; db[1] = d1; db[2] = d2; db[3] = d3; db[4] = d4;
    own_addr = own;
    ok = addr_ok(a, rw, own);
    rq = ok ? ((a == own) ? "R2" : "R3") : (rw ? "R5" : "R4");
    wv0 = wv_cnt;
    bus_start;
    send_byte({a, rw}, s);
    check(s == (ok ? 2'b00 : 2'b11), rq, "address acknowledge", 32'(s), ok ? 32'd0 : 32'd3);
    check(sda_oe == 1'b0, "R10", "release after 9th clock", 32'(sda_oe), 32'd0);
    check(busy == ok, "R9", "busy after address", 32'(busy), 32'(ok));
    for (int i = 0; i < nbytes; i++) begin
      send_byte(db[i], s);
      if (ok && i < 3)
        check(s == 2'b00, "R6", "data acknowledge", 32'(s), 32'd0);
      else
        check(s == 2'b11, ok ? "R7" : rq, "data not acknowledged", 32'(s), 32'd3);
      if (ok && i == 1) check(busy == 1'b1, "R9", "busy mid word", 32'(busy), 32'd1);
      if (ok && i == 2) begin
        check(wv_cnt == wv0 + 1, "R6", "one word issued", 32'(wv_cnt - wv0), 32'd1);
        check(last_word == {db[0], db[1], db[2]}, "R6", "word content",
              32'(last_word), 32'({db[0], db[1], db[2]}));
        check(busy == 1'b0, "R9", "busy cleared after word", 32'(busy), 32'd0);
      end
    end
    bus_stop;
    check(wv_cnt == wv0 + ((ok && nbytes >= 3) ? 1 : 0), (nbytes > 3) ? "R7" : rq,
          "word count for transfer", 32'(wv_cnt - wv0), (ok && nbytes >= 3) ? 32'd1 : 32'd0);
    check(busy == 1'b0, "R9", "busy after stop", 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary;
    $finish;
  end

  initial begin
    logic [1:0] s;
    int wv0;
    void'($urandom(32'h5EED));
    wq(3);
    check(sda_oe == 0 && word_valid == 0 && busy == 0, "R1", "outputs in reset",
          {29'd0, sda_oe, word_valid, busy}, 32'd0);
    wq(3);
    rst_ni = 1'b1;
    wq(10);
    check(sda_oe == 0 && word_valid == 0 && busy == 0, "R1", "outputs after reset",
          {29'd0, sda_oe, word_valid, busy}, 32'd0);

    // directed
    run_txn(7'h12, 1'b0, 7'h12, 3, 8'hA5, 8'h3C, 8'h81, 8'h00, 8'h00); // R2 R6
    check(last_word[23:20] == 4'hA, "R6", "command nibble", 32'(last_word[23:20]), 32'hA);
    run_txn(BCAST, 1'b0, 7'h12, 3, 8'h10, 8'hFF, 8'h01, 8'h00, 8'h00); // R3
    run_txn(7'h13, 1'b0, 7'h12, 3, 8'h11, 8'h22, 8'h33, 8'h00, 8'h00); // R4
    run_txn(7'h12, 1'b1, 7'h12, 3, 8'h44, 8'h55, 8'h66, 8'h00, 8'h00); // R5
    run_txn(BCAST, 1'b1, 7'h12, 2, 8'h44, 8'h55, 8'h66, 8'h00, 8'h00); // R5
    run_txn(7'h12, 1'b0, 7'h12, 5, 8'h3F, 8'h00, 8'hC3, 8'h77, 8'h88); // R7

    // R8: STOP in the middle of the second data byte
    wv0 = wv_cnt;
    own_addr = 7'h40;
    bus_start;
    send_byte({7'h40, 1'b0}, s);
    send_byte(8'h9E, s);
    send_bits(8'hF0, 4);
    bus_stop;
    check(wv_cnt == wv0, "R8", "no word after mid-byte stop", 32'(wv_cnt - wv0), 32'd0);
    check(busy == 1'b0, "R8", "busy cleared by stop", 32'(busy), 32'd0);

    // R8: repeated START in the middle of the third data byte, then a full transfer
    bus_start;
    send_byte({7'h40, 1'b0}, s);
    send_byte(8'h01, s);
    send_byte(8'h02, s);
    send_bits(8'hC0, 3);
    bus_start;
    check(wv_cnt == wv0 && busy == 1'b0, "R8", "no word after mid-byte start",
          32'(wv_cnt - wv0), 32'd0);
    send_byte({7'h40, 1'b0}, s);
    check(s == 2'b00, "R8", "address after restart acknowledged", 32'(s), 32'd0);
    send_byte(8'h5A, s);
    send_byte(8'h6B, s);
    send_byte(8'h7C, s);
    bus_stop;
    check(wv_cnt == wv0 + 1 && last_word == 24'h5A6B7C, "R8", "word after restart",
          32'(last_word), 32'h5A6B7C);

    // random transfers
    for (int t = 0; t < 30; t++) begin
      logic [6:0] own, a;
      bit rw;
      int kind;
      own  = 7'($urandom);
      kind = $urandom_range(0, 3);
      rw   = ($urandom_range(0, 4) == 0);
      if (kind == 1) a = BCAST;
      else if (kind == 2) begin
        a = 7'($urandom);
        while (a == own || a == BCAST) a = 7'($urandom);
      end else a = own;
      run_txn(a, rw, own, $urandom_range(0, 5), 8'($urandom), 8'($urandom),
              8'($urandom), 8'($urandom), 8'($urandom));
    end

    check(wv_double == 0, "R6", "strobe width one cycle", 32'(wv_double), 32'd0);
    summary;
    $finish;
  end
endmodule